// File: doc/BRIEF.md
# Conversion Result Slave Serial Port

This block hands a converter's result word to a host that drives its own shift clock. A start strobe begins a conversion. The conversion is modelled as a counter that runs for a fixed number of system clocks. When the counter finishes, the result word on the parallel input is latched and the busy flag drops. The host then lowers chip-select and read-enable and toggles the shift clock. The port returns the word most significant bit first, changing the data line on one shift-clock edge so the host can sample it on the other.

Several ports can share one data line by chaining. Bits arriving on the chain input follow the local word, so a host that keeps clocking past the local width collects the upstream results in order. All host-side inputs are synchronized into the system clock domain. The shift clock must run at no more than a quarter of the system clock rate.

If a read is left part way through when the next conversion finishes, the unread data is lost. The port then flags the loss with a one-cycle error pulse.

Top module: `adc_slave_sport`

## Requirements
- R1: When a conversion completes, the result word on conv_word is latched. A read then returns that word on sdout, most significant bit first, one bit per update edge of sclk.
- R2: With sclk_inv low, sdout changes only after rising edges of sclk and is stable across falling edges. With sclk_inv high, the two edges swap roles.
- R3: During a read, the level on sdin in the half period before each update edge is shifted in. After WIDTH (16) update edges, sdout therefore carries the sdin level held before the first update edge, and later bits follow in order.
- R4: If a conversion completes after 1 to WIDTH-1 update edges of a read that is still open, rd_err is high for exactly one system clock cycle and the new result replaces the old one. If no read is open, or WIDTH or more update edges have been seen, rd_err stays low.
- R5: sdout is low unless both cs_n and rd_n are low.
- R6: sclk edges while cs_n is high have no effect on the stored data or on the bit position.
- R7: A rise of cs_n ends the read. The next read starts again at the most significant bit of the held result.
- R8: busy rises in the cycle after conv_start is seen and stays high for CONV_CYCLES (40) system clock cycles. It falls as the result is latched. conv_start while busy is ignored.
- R9: A high rst aborts any conversion and drives busy, rd_err and sdout low. It also clears the held result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Starts a conversion when the port is not busy |
| conv_word | input | WIDTH | Result word, latched when the conversion completes |
| busy | output | 1 | High while a conversion runs |
| cs_n | input | 1 | Chip-select, active low; also gates sclk |
| rd_n | input | 1 | Read-enable, active low |
| sclk | input | 1 | Host shift clock |
| sclk_inv | input | 1 | Selects the falling edge as the update edge when high |
| sdin | input | 1 | Chain input from the upstream port |
| sdout | output | 1 | Serial data output |
| rd_err | output | 1 | One-cycle pulse when an open read loses its data |

## Verification
Two words of differing bit patterns are read with each setting of sclk_inv. A wrong edge choice or a bit-order slip shows up as a shifted or reversed word. A 32-bit chained read, with a distinct upstream word on sdin, separates correct pass-through from a port that repeats its own bits or counts the edges wrongly. Three further patterns exercise the gating and restart rules: shift clocks toggled while deselected, a read broken off and restarted, and read-enable held high. Conversions that complete during a 5-bit partial read, and after a full 16-bit read, tell a correct error pulse apart from a missing or spurious one. A reset in mid-conversion confirms that the conversion is aborted and the held result cleared.

// File: rtl/adc_slave_sport.sv
module adc_slave_sport #(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic [WIDTH-1:0] conv_word,
  output logic             busy,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sclk,
  input  logic             sclk_inv,
  input  logic             sdin,
  output logic             sdout,
  output logic             rd_err
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam int KW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [KW-1:0] CLAST = KW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] CFULL = CW'(WIDTH);

  logic [SYNC_STAGES-1:0] sclk_p, csn_p, rdn_p, sdin_p;
  logic                   sclk_d, csn_d;
  logic [WIDTH-1:0]       res, sreg;
  logic [CW-1:0]          bcnt;
  logic [KW-1:0]          ccnt;

  wire sclk_s  = sclk_p[SYNC_STAGES-1];
  wire csn_s   = csn_p[SYNC_STAGES-1];
  wire rdn_s   = rdn_p[SYNC_STAGES-1];
  wire sdin_s  = sdin_p[SYNC_STAGES-1];
  wire upd     = (sclk_s ^ sclk_d) & (sclk_s ^ sclk_inv) & ~csn_s;
  wire cs_rise = csn_s & ~csn_d;
  wire done    = busy && (ccnt == CLAST);
  wire reading = (bcnt != '0) && (bcnt < CFULL);

  assign sdout = sreg[WIDTH-1] & ~csn_s & ~rdn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      csn_p  <= '1;
      rdn_p  <= '1;
      sdin_p <= '0;
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      csn_p  <= {csn_p[SYNC_STAGES-2:0], cs_n};
      rdn_p  <= {rdn_p[SYNC_STAGES-2:0], rd_n};
      sdin_p <= {sdin_p[SYNC_STAGES-2:0], sdin};
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ccnt <= '0;
    end else if (!busy) begin
      busy <= conv_start;
      ccnt <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      ccnt <= ccnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      sreg   <= '0;
      bcnt   <= '0;
      rd_err <= 1'b0;
    end else if (done) begin
      res    <= conv_word;
      sreg   <= conv_word;
      bcnt   <= '0;
      rd_err <= reading;
    end else begin
      rd_err <= 1'b0;
      if (cs_rise) begin
        sreg <= res;
        bcnt <= '0;
      end else if (upd) begin
        sreg <= {sreg[WIDTH-2:0], sdin_s};
        if (bcnt != CFULL) bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

module adc_slave_sport_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_start,
  input logic [WIDTH-1:0] conv_word,
  input logic             busy,
  input logic             rd_err,
  input logic             sdout,
  input logic             cs_n,
  input logic [WIDTH-1:0] sreg
);
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> !rd_err); // R4
  AST_ERR_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> $fell(busy)); // R4
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> sreg == $past(conv_word)); // R1
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(conv_start)); // R8
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdout); // R5
  AST_RST_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !rd_err)); // R9
endmodule

bind adc_slave_sport adc_slave_sport_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_word(conv_word),
  .busy(busy), .rd_err(rd_err), .sdout(sdout), .cs_n(cs_n), .sreg(sreg)
);

// File: tb/test_adc_slave_sport.sv
module test_adc_slave_sport;
  localparam int W  = 16;
  localparam int CC = 40;

  logic clk = 0, rst = 1, conv_start = 0, cs_n = 1, rd_n = 1;
  logic sclk = 0, sclk_inv = 0, sdin = 0;
  logic [W-1:0] conv_word = '0;
  logic busy, sdout, rd_err;

  adc_slave_sport #(.WIDTH(W), .CONV_CYCLES(CC)) i_adc_slave_sport (
    .clk(clk), .rst(rst), .conv_start(conv_start), .conv_word(conv_word),
    .busy(busy), .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .sclk_inv(sclk_inv),
    .sdin(sdin), .sdout(sdout), .rd_err(rd_err));

  always #2 clk = ~clk;

  typedef struct { logic b; string tag; } exp_t;
  exp_t q[$];
  event smp_ev;
  int checks = 0, fails = 0, err_hi = 0, err_run = 0, err_max = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(smp_ev);
      e = q.pop_front();
      chk(e.tag, {31'd0, sdout}, {31'd0, e.b});
    end
  end

  always @(negedge clk) begin
    if (rd_err) begin err_hi++; err_run++; if (err_run > err_max) err_max = err_run; end
    else err_run = 0;
  end

  task automatic read_bits(int n, logic [31:0] exp, logic [W-1:0] up,
                           string tag, bit leave_low);
    exp_t e;
    sclk = sclk_inv; cs_n = 0; rd_n = 0;
    tick(8);
    for (int i = 0; i < n; i++) begin
      e.b = exp[n-1-i]; e.tag = tag;
      q.push_back(e);
      -> smp_ev;
      tick(1);
      sdin = (i < W) ? up[W-1-i] : 1'b0;
      tick(3);
      sclk = ~sclk_inv;
      tick(8);
      sclk = sclk_inv;
      tick(4);
    end
    if (!leave_low) begin cs_n = 1; rd_n = 1; tick(8); end
  endtask

  task automatic convert(logic [W-1:0] w, bit extra, string tag);
    int n = 0;
    conv_word = w; conv_start = 1; tick(1); conv_start = 0;
    while (busy && n < 1000) begin
      n++;
      if (extra && n == 10) conv_start = 1; else conv_start = 0;
      tick(1);
    end
    conv_start = 0;
    chk(tag, n, CC);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int e0;
    tick(5); rst = 0; tick(2);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset rd_err", rd_err, 0);
    chk("R9 reset sdout", sdout, 0);

    convert(16'hB3C5, 0, "R8 busy length");
    read_bits(W, 32'hB3C5, '0, "R1 R2 word rise-update", 0);
    convert(16'h4A96, 1, "R8 start ignored while busy");
    read_bits(W, 32'h4A96, '0, "R1 word2", 0);
    sclk_inv = 1; sclk = 1; tick(8);
    read_bits(W, 32'h4A96, '0, "R2 fall-update", 0);
    convert(16'hD00F, 0, "R8 busy length inv");
    read_bits(W, 32'hD00F, '0, "R2 fall-update word3", 0);
    sclk_inv = 0; sclk = 0; tick(8);

    read_bits(2 * W, {16'hD00F, 16'h5AC3}, 16'h5AC3, "R3 chained read", 0);

    for (int i = 0; i < 5; i++) begin
      sclk = 1; tick(8); chk("R5 sdout low deselected", sdout, 0);
      sclk = 0; tick(8);
    end
    read_bits(W, 32'hD00F, '0, "R6 sclk ignored while deselected", 0);

    read_bits(6, 32'h34, '0, "R7 partial read", 0);
    read_bits(W, 32'hD00F, '0, "R7 restart at msb", 0);

    cs_n = 0; rd_n = 1; tick(8);
    chk("R5 sdout low with rd_n high", sdout, 0);
    cs_n = 1; tick(8);

    e0 = err_hi; err_max = 0;
    read_bits(5, 32'h1A, '0, "R4 open read", 1);
    convert(16'h8E71, 0, "R8 busy during read");
    tick(4);
    chk("R4 error pulse count", err_hi - e0, 1);
    chk("R4 error pulse width", err_max, 1);
    cs_n = 1; rd_n = 1; tick(8);
    read_bits(W, 32'h8E71, '0, "R4 new word after error", 0);

    e0 = err_hi;
    read_bits(W, 32'h8E71, '0, "R4 full read", 1);
    convert(16'h2222, 0, "R8 busy after full read");
    tick(4);
    chk("R4 no pulse after full read", err_hi - e0, 0);
    cs_n = 1; rd_n = 1; tick(8);
    e0 = err_hi;
    convert(16'h3333, 0, "R8 idle conversion");
    tick(4);
    chk("R4 no pulse when idle", err_hi - e0, 0);

    conv_word = 16'hFFFF; conv_start = 1; tick(1); conv_start = 0;
    tick(10); rst = 1; tick(5); rst = 0; tick(2);
    chk("R9 busy cleared", busy, 0);
    tick(CC + 5);
    chk("R9 conversion aborted", busy, 0);
    read_bits(W, 32'h0, '0, "R9 result cleared", 0);

    tick(4);
    chk("scoreboard drained", q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule